// File: doc/BRIEF.md
# Pulse-position serial byte decoder

This block listens to one serial wire, sampled on the system clock, where data is carried by where fixed-width low pulses fall in time. An idle low line that rises marks the start of traffic. The block first recognises a start-of-frame pattern. It then cuts the line into fixed 192-cycle symbol slots. Each slot holds two low pulses, and the start time of each pulse gives one bit.

Four symbols make one byte, least-significant bit pair first. Each finished byte appears on an 8-bit output with a one-clock valid strobe. A frame flag is high from a recognised start of frame until the end-of-frame pattern. Any timing that fits no window drops the flag and sends the decoder back to idle, where it waits for a fresh start of frame. The input passes through a two-flop synchroniser, and every timing is measured on the synchronised signal.

Top module: `ppd_decoder`

## Requirements
- R1: While reset is asserted and directly after it, `dout` is 0x00, `dvalid` is 0 and `frame_en` is 0.
- R2: Start of frame is a high run of 16±8 cycles, then a low run of 16±8 cycles, then a rising edge. `frame_en` goes high 3 clocks after that rising edge on `din`. The first slot starts 160 cycles after that edge, and each following slot starts 192 cycles after the one before.
- R3: The upper bit of a symbol comes from the start of the first low pulse, counted from slot start. An offset of 16±8 gives 0 and an offset of 48±8 gives 1.
- R4: The lower bit comes from the start of the second low pulse. An offset of 128±8 gives 1 and an offset of 160±8 gives 0.
- R5: Symbol k of a byte (k = 0..3, in arrival order) supplies byte bits [2k+1:2k], with the upper bit at 2k+1. For example, 0x5E arrives as the pairs 10, 11, 01, 01.
- R6: `dvalid` is high for exactly one clock, 3 clocks after the falling edge on `din` that starts the second pulse of the fourth symbol. `dout` changes only together with `dvalid` and holds its value otherwise.
- R7: End of frame is recognised when a slot's first pulse fits a bit window and its second pulse starts at offset 96±8. `frame_en` falls 3 clocks after that falling edge. A partly assembled byte is dropped, and no `dvalid` is given.
- R8: A first pulse that starts outside both upper-bit windows, or a second pulse that starts outside the lower-bit and end windows, ends the frame. `frame_en` falls 3 clocks after that falling edge, no byte is given, and a later valid start of frame opens a new frame.
- R9: A low pulse in a frame that lasts outside 16±8 cycles ends the frame. `frame_en` falls 3 clocks after the rising edge that closes the pulse.
- R10: If no first pulse has started by offset 56 of a slot, the frame ends. `frame_en` falls 3 clocks after the cycle at offset 57.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Asynchronous serial line |
| dout | output | 8 | Last completed byte |
| dvalid | output | 1 | One-clock strobe when `dout` takes a new byte |
| frame_en | output | 1 | High while a frame is being received |

## Verification
The hardest cases to reach are the window edges. They are pulses that start exactly 8 cycles before or after a nominal slot offset, or that are 8 or 24 cycles wide, with a closing edge that lands on the first cycle of the next slot. The stimulus builds every symbol from explicit pulse offsets and widths measured from a slot origin that the bench tracks itself. This places pulses on the window edges, just outside them, or missing altogether. Recovery is checked too: every abort is followed by a fresh start of frame and a byte that must decode normally.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOFH,
    ST_SOFL,
    ST_LEAD,
    ST_FIRST,
    ST_SECOND,
    ST_TRAIL
  } ppd_state_e;

  // true when v lies within centre +/- tol, inclusive
  function automatic bit in_win(int v, int centre, int tol);
    return (v >= centre - tol) && (v <= centre + tol);
  endfunction

endpackage

// File: rtl/ppd_sync.sv
module ppd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ppd_edge_meter.sv
module ppd_edge_meter #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  output logic             rise,
  output logic             fall,
  output logic [RUN_W-1:0] run
);
  logic lvl_d;

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  // run holds the length of the level that was present before this cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      run   <= '0;
    end else begin
      lvl_d <= lvl;
      if (rise || fall)  run <= {{(RUN_W-1){1'b0}}, 1'b1};
      else if (run != '1) run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/ppd_fsm.sv
module ppd_fsm
  import ppd_pkg::*;
#(
  parameter int RUN_W    = 8,
  parameter int PULSE    = 16,
  parameter int TOL      = 8,
  parameter int SOF_HIGH = 16,
  parameter int LEAD     = 160,
  parameter int SLOT     = 192,
  parameter int OFF_U0   = 16,
  parameter int OFF_U1   = 48,
  parameter int OFF_L1   = 128,
  parameter int OFF_L0   = 160,
  parameter int OFF_END  = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [RUN_W-1:0] run,
  output logic             sof_ok,
  output logic             eof,
  output logic             abort,
  output logic             sym_done,
  output logic [1:0]       pair,
  output logic             frame_en
);
  localparam int SPAN  = (SLOT > LEAD) ? SLOT : LEAD;
  localparam int POS_W = $clog2(SPAN + 1);

  ppd_state_e       state, nxt;
  logic [POS_W-1:0] pos;
  logic             up_q, up_n, lo;
  logic             width_bad;
  int               p, r;

  assign p         = int'(pos);
  assign r         = int'(run);
  assign width_bad = rise && !in_win(r, PULSE, TOL);
  assign pair      = {up_q, lo};
  assign frame_en  = (state == ST_LEAD) || (state == ST_FIRST) ||
                     (state == ST_SECOND) || (state == ST_TRAIL);

  always_comb begin
    nxt      = state;
    up_n     = up_q;
    lo       = 1'b0;
    sof_ok   = 1'b0;
    eof      = 1'b0;
    abort    = 1'b0;
    sym_done = 1'b0;
    case (state)
      ST_IDLE: if (rise) nxt = ST_SOFH;
      ST_SOFH: if (fall) nxt = in_win(r, SOF_HIGH, TOL) ? ST_SOFL : ST_IDLE;
      ST_SOFL: if (rise) begin
        if (in_win(r, PULSE, TOL)) begin
          sof_ok = 1'b1;
          nxt    = ST_LEAD;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_LEAD: begin
        if (fall)               abort = 1'b1;
        else if (p == LEAD - 1) nxt   = ST_FIRST;
      end
      ST_FIRST: begin
        if (width_bad) abort = 1'b1;
        else if (fall) begin
          if (in_win(p, OFF_U0, TOL))      begin up_n = 1'b0; nxt = ST_SECOND; end
          else if (in_win(p, OFF_U1, TOL)) begin up_n = 1'b1; nxt = ST_SECOND; end
          else abort = 1'b1;
        end else if (p > OFF_U1 + TOL) abort = 1'b1;
      end
      ST_SECOND: begin
        if (width_bad) abort = 1'b1;
        else if (fall) begin
          if (in_win(p, OFF_L1, TOL)) begin
            lo = 1'b1; sym_done = 1'b1; nxt = ST_TRAIL;
          end else if (in_win(p, OFF_L0, TOL)) begin
            lo = 1'b0; sym_done = 1'b1; nxt = ST_TRAIL;
          end else if (in_win(p, OFF_END, TOL)) begin
            eof = 1'b1; nxt = ST_IDLE;
          end else abort = 1'b1;
        end else if (p > OFF_L0 + TOL) abort = 1'b1;
      end
      ST_TRAIL: begin
        if (width_bad || fall)  abort = 1'b1;
        else if (p == SLOT - 1) nxt   = ST_FIRST;
      end
      default: nxt = ST_IDLE;
    endcase
    if (abort) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pos   <= '0;
      up_q  <= 1'b0;
    end else begin
      state <= nxt;
      up_q  <= up_n;
      if (sof_ok) pos <= {{(POS_W-1){1'b0}}, 1'b1};
      else begin
        case (state)
          ST_LEAD:                      pos <= (p == LEAD - 1) ? '0 : pos + 1'b1;
          ST_FIRST, ST_SECOND, ST_TRAIL: pos <= (p == SLOT - 1) ? '0 : pos + 1'b1;
          default:                      pos <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ppd_assembler.sv
module ppd_assembler #(
  parameter int PAIRS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 sym_done,
  input  logic [1:0]           pair,
  output logic [2*PAIRS-1:0]   dout,
  output logic                 dvalid
);
  localparam int IW = $clog2(PAIRS);

  logic [2*PAIRS-1:0] acc;
  logic [IW-1:0]      idx;

  // place a bit pair at slot k, lowest slot first
  function automatic logic [2*PAIRS-1:0] put_pair(logic [2*PAIRS-1:0] a,
                                                  logic [IW-1:0] k,
                                                  logic [1:0] pr);
    logic [2*PAIRS-1:0] res;
    res = a;
    res[{k, 1'b0} +: 2] = pr;
    return res;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      idx    <= '0;
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      dvalid <= 1'b0;
      if (clear) begin
        acc <= '0;
        idx <= '0;
      end else if (sym_done) begin
        if (int'(idx) == PAIRS - 1) begin
          dout   <= put_pair(acc, idx, pair);
          dvalid <= 1'b1;
          acc    <= '0;
          idx    <= '0;
        end else begin
          acc <= put_pair(acc, idx, pair);
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppd_decoder.sv
module ppd_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_W       = 8,
  parameter int PAIRS       = 4,
  parameter int PULSE       = 16,
  parameter int TOL         = 8,
  parameter int SOF_HIGH    = 16,
  parameter int LEAD        = 160,
  parameter int SLOT        = 192,
  parameter int OFF_U0      = 16,
  parameter int OFF_U1      = 48,
  parameter int OFF_L1      = 128,
  parameter int OFF_L0      = 160,
  parameter int OFF_END     = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  output logic [2*PAIRS-1:0] dout,
  output logic               dvalid,
  output logic               frame_en
);
  logic             lvl, rise, fall;
  logic [RUN_W-1:0] run;
  logic             sof_ok, eof, abort, sym_done;
  logic [1:0]       pair;

  ppd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din), .q(lvl)
  );

  ppd_edge_meter #(.RUN_W(RUN_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall), .run(run)
  );

  ppd_fsm #(
    .RUN_W(RUN_W), .PULSE(PULSE), .TOL(TOL), .SOF_HIGH(SOF_HIGH),
    .LEAD(LEAD), .SLOT(SLOT), .OFF_U0(OFF_U0), .OFF_U1(OFF_U1),
    .OFF_L1(OFF_L1), .OFF_L0(OFF_L0), .OFF_END(OFF_END)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .run(run),
    .sof_ok(sof_ok), .eof(eof), .abort(abort), .sym_done(sym_done),
    .pair(pair), .frame_en(frame_en)
  );

  ppd_assembler #(.PAIRS(PAIRS)) u_asm (
    .clk(clk), .rst_n(rst_n), .clear(sof_ok | eof | abort),
    .sym_done(sym_done), .pair(pair), .dout(dout), .dvalid(dvalid)
  );
endmodule

// File: rtl/ppd_checker.sv
module ppd_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] dout,
  input logic         dvalid,
  input logic         frame_en,
  input logic         sof_ok,
  input logic         eof,
  input logic         abort,
  input logic         sym_done
);
  AST_FRAME_RISE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_en) |-> $past(sof_ok)); // R2
  AST_DV_FROM_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(sym_done)); // R5
  AST_DV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |=> !dvalid); // R6
  AST_DV_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> frame_en); // R6
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid |-> $stable(dout)); // R6
  AST_FRAME_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_en) |-> $past(eof || abort)); // R7
endmodule

bind ppd_decoder ppd_checker #(.W(2*PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout), .dvalid(dvalid),
  .frame_en(frame_en), .sof_ok(sof_ok), .eof(eof), .abort(abort),
  .sym_done(sym_done)
);

// File: tb/sim_ppd_decoder.sv
`timescale 1ns/1ps
module sim_ppd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic [7:0] dout;
  logic       dvalid, frame_en;

  ppd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .din(din),
    .dout(dout), .dvalid(dvalid), .frame_en(frame_en)
  );

  always #2 clk = ~clk;

  int     compared = 0, mismatched = 0;
  int     tcur = 0;
  int     origin = 0;
  int     widx = 0;
  int     fe_ev[int];
  int     dv_ev[int];
  logic [7:0] acc = 8'h00;
  logic [7:0] exp_dout = 8'h00;
  logic   exp_fe = 1'b0;
  logic   exp_dv;
  bit     mon_on = 1'b0;
  bit     done = 1'b0;
  string  req = "R1";
  int     wdog = 0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(string tag, int act, int expv, string what);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s %s at t=%0d: actual %0h expected %0h", tag, what, tcur, act, expv);
    end
  endtask

  // per-clock comparison with the expectation schedule
  always @(negedge clk) begin
    wdog++;
    if (wdog > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
    if (mon_on) begin
      if (fe_ev.exists(tcur)) exp_fe = fe_ev[tcur][0];
      exp_dv = dv_ev.exists(tcur);
      if (exp_dv) exp_dout = dv_ev[tcur][7:0];
      check(req, int'(frame_en), int'(exp_fe), "frame_en");
      check(req, int'(dvalid), int'(exp_dv), "dvalid");
      check(req, int'(dout), int'(exp_dout), "dout");
    end
  end

  task automatic drv(logic v, int len);
    repeat (len) begin
      @(posedge clk);
      tcur = tcur + 1;
      din <= v;
    end
  endtask

  function automatic bit near(int v, int c);
    return (v - c <= 8) && (c - v <= 8);
  endfunction

  // start of frame; frame_en expected 3 clocks after the final rising edge (R2)
  task automatic sof();
    int redge;
    drv(1'b1, 16);
    drv(1'b0, 16);
    redge = tcur + 1;
    fe_ev[redge + 3] = 1;
    origin = redge + 160;
    acc = 8'h00;
    widx = 0;
    drv(1'b1, 160);
  endtask

  // one slot with explicit pulse offsets and widths
  task automatic sym(int o1, int w1, int o2, int w2);
    int f1, f2, u, l;
    f1 = origin + o1;
    f2 = origin + o2;
    u  = near(o1, 16) ? 0 : near(o1, 48) ? 1 : -1;      // R3
    drv(1'b1, o1);
    if (u < 0) begin                                     // R8
      fe_ev[f1 + 3] = 0; drv(1'b0, 64); return;
    end
    if (w1 < 8 || w1 > 24) begin                         // R9
      fe_ev[f1 + w1 + 3] = 0;
      drv(1'b0, w1); drv(1'b1, 1); drv(1'b0, 64); return;
    end
    drv(1'b0, w1);
    drv(1'b1, o2 - o1 - w1);
    l = near(o2, 128) ? 1 : near(o2, 160) ? 0 : near(o2, 96) ? 2 : -1;  // R4
    if (l < 0) begin                                     // R8
      fe_ev[f2 + 3] = 0; drv(1'b0, 64); return;
    end
    if (l == 2) begin                                    // R7: partial byte dropped
      fe_ev[f2 + 3] = 0;
      drv(1'b0, w2); drv(1'b1, 32); drv(1'b0, 64); return;
    end
    acc[2*widx +: 2] = {u[0], l[0]};                     // R5
    if (widx == 3) dv_ev[f2 + 3] = int'(acc);            // R6
    widx = (widx + 1) % 4;
    if (w2 < 8 || w2 > 24) begin                         // R9
      fe_ev[f2 + w2 + 3] = 0;
      drv(1'b0, w2); drv(1'b1, 1); drv(1'b0, 64); return;
    end
    drv(1'b0, w2);
    drv(1'b1, 192 - o2 - w2);
    origin = origin + 192;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int k = 0; k < 4; k++)
      sym(b[2*k+1] ? 48 : 16, 16, b[2*k] ? 128 : 160, 16);
  endtask

  task automatic end_frame(int o2);
    sym(48, 16, o2, 16);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values while reset is held
    check("R1", int'(dout), 0, "dout in reset");
    check("R1", int'(dvalid), 0, "dvalid in reset");
    check("R1", int'(frame_en), 0, "frame_en in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(frame_en), 0, "frame_en after reset");
    check("R1", int'(dout), 0, "dout after reset");
    mon_on = 1'b1;
    drv(1'b0, 20);

    req = "R2 R3 R4 R5 R6 R7 nominal bytes";
    sof();
    send_byte(8'h5E);
    send_byte(8'h6F);
    send_byte(8'h7A);
    end_frame(96);

    req = "R3 R4 R6 window edges";
    sof();
    sym(8, 8, 120, 24);
    sym(24, 24, 168, 24);
    sym(40, 16, 152, 16);
    sym(56, 16, 136, 16);
    req = "R7 partial byte at end window edge";
    sym(16, 16, 128, 16);
    sym(48, 16, 160, 16);
    end_frame(88);

    req = "R8 bad first offset";
    sof();
    send_byte(8'h3C);
    sym(32, 16, 128, 16);
    req = "R8 recovery";
    sof();
    send_byte(8'hA5);
    end_frame(104);

    req = "R8 bad second offset";
    sof();
    sym(16, 16, 144, 16);

    req = "R9 wide pulse";
    sof();
    sym(16, 30, 128, 16);
    req = "R9 narrow pulse";
    sof();
    sym(48, 5, 160, 16);

    req = "R10 missing first pulse";
    sof();
    sym(48, 16, 128, 16);
    fe_ev[origin + 60] = 0;
    drv(1'b1, 70);
    drv(1'b0, 64);

    req = "R5 R6 after recovery";
    sof();
    send_byte(8'h00);
    send_byte(8'hFF);
    end_frame(96);
    drv(1'b0, 20);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule